// File: doc/BRIEF.md
# Cartridge Program/Character Bank Mapper

This block translates the narrow address buses of a game console into wide ROM addresses for a cartridge. It watches CPU writes in two windows. The expansion window is 0x5000–0x5FFF and the ROM window is 0x8000–0xFFFF. From those writes it keeps four 8 KB program slots and eight 1 KB character slots. It then forms the program-ROM address from the CPU address and the character-ROM address from the PPU address, both combinationally.

Besides the common select/data register pair, the block has three other controls:

- A mode register at 0x5000 can force 16 KB or 32 KB program selections.
- A second select port at 0x8003 arms a set of fixed bank patches.
- Reads in the expansion window return a small protection byte, chosen by the low two bits of the most recent byte written.

The nametable mirroring select is also held here. The program ROM size, counted in 8 KB pages, is a parameter (`PRG_PAGES`, from 4 to 256).

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset, program slots 0..3 hold pages P-4, P-3, P-2, P-1 (P = `PRG_PAGES`), all eight character slots hold 0, `mirror_horiz` is 0 and `exp_rdata` is 0x83.
- R2: A write to 0x8000 stores the select byte and disarms patches. A write to 0x8003 stores the select byte and arms patches. If bits [7:4] of the 0x8003 byte are all zero, program slot 2 also returns to page P-2.
- R3: A 0x8001 write with patches disarmed and select bits [2:0] = 0 sets character slots 4 and 5 to 0x100 + (data & 0xFE) and that value + 1. Select value 1 does the same for slots 6 and 7.
- R4: A 0x8001 write with patches disarmed and select bits [2:0] = 2, 3, 4 or 5 loads character slot 0, 1, 2 or 3 with the data byte.
- R5: A 0x8001 write with patches disarmed and select bits [2:0] = 6 or 7 loads program slot 0 or 1. This does not happen while mode bits 7 and 5 are both 1.
- R6: A 0x8001 write with patches armed does no normal banking. A full select byte of 0x2A sets program slot 1 to 0x0F, and 0x28 sets program slot 2 to 0x17. Any other select byte changes no slot.
- R7: A 0x5000 write with bits 7 and 5 set loads program slots 0..3 with 4·data[4:1] + 0, 1, 2, 3.
- R8: A 0x5000 write with bit 7 set and bit 5 clear loads only slots 2 and 3, with 2·data[4:0] + 0 and + 1.
- R9: Every 0x8001 write with select bits [2:0] = 6 or 7 saves its data, armed or locked or not. A 0x5000 write with bit 7 clear reloads slots 0 and 1 from those saved bytes and returns slots 2 and 3 to pages P-2 and P-1.
- R10: A write to 0xA000 sets `mirror_horiz` to data bit 0. Other ROM-window addresses leave it alone.
- R11: `exp_rdata` is 0x83, 0x83, 0x42 or 0x00 when bits [1:0] of the last byte written in either window are 0, 1, 2 or 3.
- R12: For CPU addresses 0x8000–0xFFFF, `prg_rom_addr` = {slot[cpu_addr[14:13]] mod P, cpu_addr[12:0]}. Out-of-range page numbers wrap.
- R13: `chr_rom_addr` = {9-bit slot[ppu_addr[12:10]], ppu_addr[9:0]}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address, used for both write decode and translation |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| ppu_addr | input | 13 | PPU pattern address |
| prg_rom_addr | output | clog2(PRG_PAGES)+13 | Translated program-ROM address |
| chr_rom_addr | output | 19 | Translated character-ROM address |
| exp_rdata | output | 8 | Protection byte for expansion-window reads |
| mirror_horiz | output | 1 | 1 = horizontal mirroring, 0 = vertical |

## Verification
All bank state shows up directly in the translation, so a wrong register value appears on the next cycle. It shows on `prg_rom_addr` or `chr_rom_addr` as soon as the bench points the CPU or PPU address at the affected slot. A wrong patch or lock flag is not visible by itself. It becomes visible only on the next 0x8001 write, which then changes a slot that should have held, or leaves alone a slot that should have changed. The saved slot-6/7 bytes are even more hidden. They show only when a mode write with bit 7 clear reloads them, so the bench fills them under patch and lock conditions and reloads them later.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;
    localparam int PBANK_W = 8;   // program page number width
    localparam int CBANK_W = 9;   // character 1 KB page number width
    localparam int PSLOTS  = 4;
    localparam int CSLOTS  = 8;

    localparam logic [15:0] A_MODE  = 16'h5000;
    localparam logic [15:0] A_SEL   = 16'h8000;
    localparam logic [15:0] A_DATA  = 16'h8001;
    localparam logic [15:0] A_SELPT = 16'h8003;
    localparam logic [15:0] A_MIRR  = 16'hA000;

    typedef struct packed {
        logic [PSLOTS-1:0][PBANK_W-1:0] prg;
        logic [CSLOTS-1:0][CBANK_W-1:0] chr;
        logic [1:0][7:0]                keep;     // saved data of selects 6 and 7
        logic [7:0]                     sel;
        logic                           patch;
        logic [7:0]                     mode;
        logic                           mirror_h;
        logic [7:0]                     last;
    } map_state_t;
endpackage

// File: rtl/cart_map_regs.sv
module cart_map_regs
    import cart_map_pkg::*;
#(
    parameter int PRG_PAGES = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    input  logic        cpu_we,
    output map_state_t  st
);
    localparam logic [7:0] PG_M1 = 8'(PRG_PAGES - 1);
    localparam logic [7:0] PG_M2 = 8'(PRG_PAGES - 2);

    map_state_t st_d, st_q;
    logic       lock;
    logic       in_lo, in_hi;

    assign lock  = st_q.mode[7] & st_q.mode[5];
    assign in_lo = (cpu_addr[15:12] == 4'h5);
    assign in_hi = cpu_addr[15];

    always_comb begin
        st_d = st_q;
        if (cpu_we) begin
            if (in_lo || in_hi) st_d.last = cpu_wdata;
            case (cpu_addr)
                A_MODE: begin
                    st_d.mode = cpu_wdata;
                    if (cpu_wdata[7]) begin
                        if (cpu_wdata[5]) begin
                            for (int i = 0; i < PSLOTS; i++)
                                st_d.prg[i] = {2'b00, cpu_wdata[4:1], 2'b00} | 8'(i);
                        end else begin
                            st_d.prg[2] = {2'b00, cpu_wdata[4:0], 1'b0};
                            st_d.prg[3] = {2'b00, cpu_wdata[4:0], 1'b1};
                        end
                    end else begin
                        st_d.prg[0] = st_q.keep[0];
                        st_d.prg[1] = st_q.keep[1];
                        st_d.prg[2] = PG_M2;
                        st_d.prg[3] = PG_M1;
                    end
                end
                A_SEL: begin
                    st_d.sel   = cpu_wdata;
                    st_d.patch = 1'b0;
                end
                A_SELPT: begin
                    st_d.sel   = cpu_wdata;
                    st_d.patch = 1'b1;
                    if (cpu_wdata[7:4] == 4'h0) st_d.prg[2] = PG_M2;
                end
                A_DATA: begin
                    if (st_q.sel[2:0] == 3'd6) st_d.keep[0] = cpu_wdata;
                    if (st_q.sel[2:0] == 3'd7) st_d.keep[1] = cpu_wdata;
                    if (!st_q.patch) begin
                        case (st_q.sel[2:0])
                            3'd0: begin
                                st_d.chr[4] = {1'b1, cpu_wdata[7:1], 1'b0};
                                st_d.chr[5] = {1'b1, cpu_wdata[7:1], 1'b1};
                            end
                            3'd1: begin
                                st_d.chr[6] = {1'b1, cpu_wdata[7:1], 1'b0};
                                st_d.chr[7] = {1'b1, cpu_wdata[7:1], 1'b1};
                            end
                            3'd6: if (!lock) st_d.prg[0] = cpu_wdata;
                            3'd7: if (!lock) st_d.prg[1] = cpu_wdata;
                            default: st_d.chr[st_q.sel[2:0] - 3'd2] = {1'b0, cpu_wdata};
                        endcase
                    end else begin
                        if (st_q.sel == 8'h2A) st_d.prg[1] = 8'h0F;
                        if (st_q.sel == 8'h28) st_d.prg[2] = 8'h17;
                    end
                end
                A_MIRR: st_d.mirror_h = cpu_wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < PSLOTS; i++)
                st_q.prg[i] <= 8'(PRG_PAGES - PSLOTS + i);
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;

    // R3: a pair load leaves the two slots adjacent, odd one above
    p_pair_adjacent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == A_DATA && !st_q.patch && st_q.sel[2:0] == 3'd0)
        |=> (st_q.chr[5] == st_q.chr[4] + 9'd1) && st_q.chr[4][8] && !st_q.chr[4][0]);

    // R5: locked mode keeps program slot 0 on a select-6 load
    p_lock_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == A_DATA && !st_q.patch && st_q.sel[2:0] == 3'd6 && lock)
        |=> st_q.prg[0] == $past(st_q.prg[0]));

    // R6: armed patch with an unlisted select changes no slot
    p_patch_other_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == A_DATA && st_q.patch && st_q.sel != 8'h2A && st_q.sel != 8'h28)
        |=> st_q.prg == $past(st_q.prg) && st_q.chr == $past(st_q.chr));

    // R7: 32 KB mode write sets slot 0 from data bits 4:1
    p_mode32_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == A_MODE && cpu_wdata[7] && cpu_wdata[5])
        |=> st_q.prg[0] == {2'b00, $past(cpu_wdata[4:1]), 2'b00});

    // R10: mirroring follows bit 0 of the 0xA000 write
    p_mirror_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == A_MIRR) |=> st_q.mirror_h == $past(cpu_wdata[0]));
endmodule

// File: rtl/cart_prg_xlate.sv
module cart_prg_xlate
    import cart_map_pkg::*;
#(
    parameter  int PRG_PAGES = 32,
    localparam int PW        = $clog2(PRG_PAGES),
    localparam int AW        = PW + 13
) (
    input  logic [PSLOTS-1:0][PBANK_W-1:0] banks,
    input  logic [14:0]                    cpu_addr,
    output logic [AW-1:0]                  rom_addr
);
    logic [PBANK_W-1:0] pick;
    logic [8:0]         wrapped;

    assign pick     = banks[cpu_addr[14:13]];
    assign wrapped  = 9'(pick) % 9'(PRG_PAGES);
    assign rom_addr = {wrapped[PW-1:0], cpu_addr[12:0]};
endmodule

// File: rtl/cart_chr_xlate.sv
module cart_chr_xlate
    import cart_map_pkg::*;
(
    input  logic [CSLOTS-1:0][CBANK_W-1:0] banks,
    input  logic [12:0]                    ppu_addr,
    output logic [CBANK_W+9:0]             rom_addr
);
    assign rom_addr = {banks[ppu_addr[12:10]], ppu_addr[9:0]};
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import cart_map_pkg::*;
#(
    parameter  int PRG_PAGES = 32,
    localparam int PRG_AW    = $clog2(PRG_PAGES) + 13,
    localparam int CHR_AW    = CBANK_W + 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_we,
    input  logic [12:0]       ppu_addr,
    output logic [PRG_AW-1:0] prg_rom_addr,
    output logic [CHR_AW-1:0] chr_rom_addr,
    output logic [7:0]        exp_rdata,
    output logic              mirror_horiz
);
    map_state_t st;

    cart_map_regs #(.PRG_PAGES(PRG_PAGES)) u_regs (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_we(cpu_we), .st(st)
    );

    cart_prg_xlate #(.PRG_PAGES(PRG_PAGES)) u_prg (
        .banks(st.prg), .cpu_addr(cpu_addr[14:0]), .rom_addr(prg_rom_addr)
    );

    cart_chr_xlate u_chr (
        .banks(st.chr), .ppu_addr(ppu_addr), .rom_addr(chr_rom_addr)
    );

    always_comb begin
        case (st.last[1:0])
            2'd0, 2'd1: exp_rdata = 8'h83;
            2'd2:       exp_rdata = 8'h42;
            default:    exp_rdata = 8'h00;
        endcase
    end

    assign mirror_horiz = st.mirror_h;
endmodule

// File: tb/tb_cart_bank_mapper.sv
module tb_cart_bank_mapper;
    localparam int P = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0;
    logic [7:0]  cpu_wdata = 8'h0;
    logic        cpu_we = 1'b0;
    logic [12:0] ppu_addr = 13'h0;
    logic [17:0] prg_rom_addr;
    logic [18:0] chr_rom_addr;
    logic [7:0]  exp_rdata;
    logic        mirror_horiz;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cart_bank_mapper #(.PRG_PAGES(P)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .ppu_addr(ppu_addr), .prg_rom_addr(prg_rom_addr),
        .chr_rom_addr(chr_rom_addr), .exp_rdata(exp_rdata), .mirror_horiz(mirror_horiz)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic chk_prg(string req, int slot, int bank);
        cpu_addr = 16'h8000 | 16'(slot << 13) | 16'h0ABC;
        #1;
        chk(req, int'(prg_rom_addr), (bank % P) * 8192 + 'hABC);
    endtask

    task automatic chk_chr(string req, int slot, int bank);
        ppu_addr = 13'(slot << 10) | 13'h155;
        #1;
        chk(req, int'(chr_rom_addr), bank * 1024 + 'h155);
    endtask

    task automatic t_reset;
        for (int s = 0; s < 4; s++) chk_prg("R1 reset prg", s, P - 4 + s);
        for (int s = 0; s < 8; s++) chk_chr("R1 reset chr", s, 0);
        chk("R1 reset mirror", int'(mirror_horiz), 0);
        chk("R1 reset rdata", int'(exp_rdata), 'h83);
    endtask

    task automatic t_chr;
        wr(16'h8000, 8'h00); wr(16'h8001, 8'h35);
        chk_chr("R3 pair4", 4, 'h134); chk_chr("R3 pair5", 5, 'h135);
        wr(16'h8000, 8'h01); wr(16'h8001, 8'h10);
        chk_chr("R3 pair6", 6, 'h110); chk_chr("R3 pair7", 7, 'h111);
        for (int k = 2; k < 6; k++) begin
            wr(16'h8000, 8'(k)); wr(16'h8001, 8'(8'hA0 + k));
        end
        for (int k = 0; k < 4; k++) chk_chr("R4 1KB slot", k, 'hA2 + k);
        chk_chr("R13 slot4 kept", 4, 'h134);
    endtask

    task automatic t_prg;
        wr(16'h8000, 8'h06); wr(16'h8001, 8'h25);
        chk_prg("R5/R12 slot0 wrap", 0, 'h25);
        wr(16'h8000, 8'h07); wr(16'h8001, 8'h03);
        chk_prg("R5 slot1", 1, 3);
    endtask

    task automatic t_mode;
        wr(16'h5000, 8'hA6);
        for (int s = 0; s < 4; s++) chk_prg("R7 32KB", s, 12 + s);
        wr(16'h8000, 8'h06); wr(16'h8001, 8'h01);
        chk_prg("R5 locked", 0, 12);
        wr(16'h5000, 8'h8B);
        chk_prg("R8 slot2", 2, 22); chk_prg("R8 slot3", 3, 23);
        chk_prg("R8 slot0 kept", 0, 12); chk_prg("R8 slot1 kept", 1, 13);
        wr(16'h5000, 8'h00);
        chk_prg("R9 reload0", 0, 1); chk_prg("R9 reload1", 1, 3);
        chk_prg("R9 slot2", 2, P - 2); chk_prg("R9 slot3", 3, P - 1);
    endtask

    task automatic t_patch;
        wr(16'h8003, 8'h2A); wr(16'h8001, 8'h55);
        chk_prg("R6 2A slot1", 1, 'h0F);
        chk_chr("R6 no chr", 0, 'hA2);
        wr(16'h8003, 8'h28); wr(16'h8001, 8'h77);
        chk_prg("R6 28 slot2", 2, 'h17);
        wr(16'h8003, 8'h26); wr(16'h8001, 8'h44);
        chk_prg("R6 other s0", 0, 1); chk_prg("R6 other s1", 1, 'h0F);
        chk_prg("R6 other s2", 2, 'h17); chk_prg("R6 other s3", 3, P - 1);
        wr(16'h8003, 8'h2F); wr(16'h8001, 8'h09);
        chk_prg("R6 no prg1", 1, 'h0F);
        wr(16'h5000, 8'h00);
        chk_prg("R9 saved while armed", 1, 9);
        wr(16'h8000, 8'h02); wr(16'h8001, 8'h66);
        chk_chr("R2 8000 disarms", 0, 'h66);
    endtask

    task automatic t_nibble;
        wr(16'h5000, 8'h80);
        chk_prg("R8 slot2 zero", 2, 0);
        wr(16'h8003, 8'h05);
        chk_prg("R2 nibble0 slot2", 2, P - 2);
        chk_prg("R2 slot3 kept", 3, 1);
        wr(16'h5000, 8'h80);
        wr(16'h8003, 8'h15);
        chk_prg("R2 nibble nonzero", 2, 0);
    endtask

    task automatic t_mirror;
        wr(16'hA000, 8'h01); chk("R10 horiz", int'(mirror_horiz), 1);
        wr(16'hA000, 8'h02); chk("R10 vert", int'(mirror_horiz), 0);
        wr(16'hA001, 8'h01); chk("R10 other addr", int'(mirror_horiz), 0);
    endtask

    task automatic t_protect;
        int tbl[4] = '{'h83, 'h83, 'h42, 'h00};
        for (int k = 0; k < 4; k++) begin
            wr(16'hA001, 8'(8'h10 + k));
            chk("R11 hi window", int'(exp_rdata), tbl[k]);
        end
        wr(16'h5800, 8'h02);
        chk("R11 lo window", int'(exp_rdata), 'h42);
        wr(16'h3000, 8'h01);
        chk("R11 outside ignored", int'(exp_rdata), 'h42);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_chr();
        t_prg();
        t_mode();
        t_patch();
        t_nibble();
        t_mirror();
        t_protect();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule